// File: doc/BRIEF.md
# Cross-Domain Pulse Count Checker

This block shows whether a clock-domain crossing behaves correctly. It produces periodic pulses in a source clock domain and counts them along three paths at the same time. A reference counter counts the pulses in the source domain. A raw counter counts them in a destination domain with no synchronization. A synchronized counter counts them in the destination domain after a toggle pulse synchronizer. Once the pulses stop, the synchronized count agrees with the reference count. The raw count shows the crossing error: it counts too many when the destination clock is faster and too few when it is slower.

The destination domain is also the control side. The generator enable and the pulse spacing are set from there. The enable is a level and passes through a two-flop synchronizer into the source domain. The spacing value is captured on the rising edge of a load flag and then carried across as a pulse-qualified word transfer. After reset the generator stays quiet, with a nonzero default spacing, until the enable is raised.

Top module: `xdom_pulse_counter`

## Requirements
- R1: While enabled, the generator emits a pulse one source cycle wide each time its phase counter reaches the programmed rate, then restarts at zero. This gives one pulse every rate+1 source cycles. If a new rate lower than the current phase arrives, the phase restarts on the next cycle and does not run on to wrap.
- R2: The reference count, in the source domain, rises by exactly one for each generated pulse and does not change otherwise.
- R3: The raw count, in the destination domain, rises by one on every destination edge at which the unsynchronized pulse is high. With a 50 MHz source and a destination near 141.4 MHz, each pulse is counted at least twice. In the reverse case, fewer pulses are counted than were generated.
- R4: The synchronized count rises by one for each one-cycle strobe from a toggle / two-flop / XOR synchronizer. Once pulses have stopped and settled, it equals the reference count, provided the rate is greater than 2 × f_src / f_dst.
- R5: The enable reaches the generator through a two-flop level synchronizer in the source domain. While it is low, no pulse is emitted, the phase is cleared, and all three counts hold their values.
- R6: On a 0-to-1 transition of the load flag, the destination domain captures the rate input and sends it to the source domain. The source rate register changes only when that transfer is delivered. A flag that stays high, or any rate input change made without a new rising edge, has no effect.
- R7: The asynchronous active-low resets clear all three counts to zero at once and return the source rate to RATE_RST (nonzero, default 15). The generator stays idle until it is enabled.
- R8: All counts are COUNT_W bits wide (default 24) and wrap from all-ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source (pulse) domain clock |
| rst_src_n | input | 1 | Source domain reset, asynchronous assert, active low |
| clk_dst | input | 1 | Destination / control domain clock |
| rst_dst_n | input | 1 | Destination domain reset, asynchronous assert, active low |
| gen_en_i | input | 1 | Generator enable level (destination domain) |
| rate_i | input | RATE_W | Rate value to transfer (destination domain) |
| rate_load_i | input | 1 | Load flag; its rising edge launches a rate transfer |
| ref_count_o | output | COUNT_W | Reference count (source domain) |
| raw_count_o | output | COUNT_W | Unsynchronized count (destination domain) |
| sync_count_o | output | COUNT_W | Synchronized count (destination domain) |

## Verification
Two source-domain events can fall in the same cycle. A new rate can be delivered in the same cycle that the phase counter reaches or passes the old rate. A new rate can also be delivered while the phase already lies beyond the new value. The bench provokes both by loading a large rate, letting the phase run well past small values, and then loading a small rate while the generator runs. It judges the result by measuring the exact pulse spacing over a window afterwards, and by checking that the synchronized count still equals the reference count once the generator is stopped. Both clock ratios are run: the fast destination and the slow destination.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  // Flop count of every synchronizer chain in the block.
  localparam int unsigned SYNC_STAGES = 2;

  // Generator operating state.
  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_mode_e;
endpackage

// File: rtl/pcc_bit_sync.sv
module pcc_bit_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = pcc_pkg::SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pcc_pulse_sync.sv
module pcc_pulse_sync #(
  parameter int unsigned STAGES = pcc_pkg::SYNC_STAGES
) (
  input  logic clk_a,
  input  logic rst_a_n,
  input  logic pulse_a,
  input  logic clk_b,
  input  logic rst_b_n,
  output logic pulse_b
);
  logic tog_q, tog_d;
  logic lvl_b, last_q;

  // Source side: each pulse flips a level.
  always_comb tog_d = pulse_a ? ~tog_q : tog_q;

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) tog_q <= 1'b0;
    else          tog_q <= tog_d;
  end

  pcc_bit_sync #(.WIDTH(1), .STAGES(STAGES)) u_lvl (
    .clk     (clk_b),
    .rst_n   (rst_b_n),
    .d_async (tog_q),
    .q_sync  (lvl_b)
  );

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) last_q <= 1'b0;
    else          last_q <= lvl_b;
  end

  // Any edge of the synchronized level is one strobe.
  assign pulse_b = lvl_b ^ last_q;
endmodule

// File: rtl/pcc_word_xfer.sv
module pcc_word_xfer #(
  parameter int unsigned WIDTH   = 24,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_a,
  input  logic             rst_a_n,
  input  logic             load_a,
  input  logic [WIDTH-1:0] data_a,
  input  logic             clk_b,
  input  logic             rst_b_n,
  output logic [WIDTH-1:0] data_b,
  output logic             upd_b
);
  logic             flag_q;
  logic             launch;
  logic [WIDTH-1:0] hold_q, hold_d;
  logic [WIDTH-1:0] dest_q, dest_d;

  always_comb begin
    launch = load_a & ~flag_q;
    hold_d = launch ? data_a : hold_q;
  end

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) begin
      flag_q <= 1'b0;
      hold_q <= RST_VAL;
    end else begin
      flag_q <= load_a;
      hold_q <= hold_d;
    end
  end

  pcc_pulse_sync u_qual (
    .clk_a   (clk_a),
    .rst_a_n (rst_a_n),
    .pulse_a (launch),
    .clk_b   (clk_b),
    .rst_b_n (rst_b_n),
    .pulse_b (upd_b)
  );

  // hold_q is quiet while the qualifier travels, so it is sampled directly.
  always_comb dest_d = upd_b ? hold_q : dest_q;

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n) dest_q <= RST_VAL;
    else          dest_q <= dest_d;
  end

  assign data_b = dest_q;
endmodule

// File: rtl/pcc_pulse_gen.sv
module pcc_pulse_gen #(
  parameter int unsigned RATE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              pulse
);
  import pcc_pkg::*;

  gen_mode_e         mode;
  logic [RATE_W-1:0] phase_q, phase_d;
  logic              pulse_q, pulse_d;
  logic              hit;

  always_comb begin
    mode    = en ? GEN_RUN : GEN_IDLE;
    hit     = (phase_q >= rate);
    phase_d = '0;
    pulse_d = 1'b0;
    if (mode == GEN_RUN) begin
      if (hit) begin
        phase_d = '0;
        pulse_d = 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/pcc_counter.sv
module pcc_counter #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb cnt_d = inc ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/xdom_pulse_counter.sv
module xdom_pulse_counter #(
  parameter int unsigned COUNT_W  = 24,
  parameter int unsigned RATE_W   = 24,
  parameter int unsigned RATE_RST = 15
) (
  input  logic               clk_src,
  input  logic               rst_src_n,
  input  logic               clk_dst,
  input  logic               rst_dst_n,
  input  logic               gen_en_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic               rate_load_i,
  output logic [COUNT_W-1:0] ref_count_o,
  output logic [COUNT_W-1:0] raw_count_o,
  output logic [COUNT_W-1:0] sync_count_o
);
  localparam logic [RATE_W-1:0] RATE_INIT = RATE_W'(RATE_RST);

  logic              en_src;
  logic [RATE_W-1:0] rate_src;
  logic              rate_upd_src;
  logic              pulse_src;
  logic              strobe_dst;

  // Enable level into the pulse domain.
  pcc_bit_sync #(.WIDTH(1)) u_en_sync (
    .clk     (clk_src),
    .rst_n   (rst_src_n),
    .d_async (gen_en_i),
    .q_sync  (en_src)
  );

  // Rate word from the control side, qualified by a flag edge.
  pcc_word_xfer #(.WIDTH(RATE_W), .RST_VAL(RATE_INIT)) u_rate_xfer (
    .clk_a   (clk_dst),
    .rst_a_n (rst_dst_n),
    .load_a  (rate_load_i),
    .data_a  (rate_i),
    .clk_b   (clk_src),
    .rst_b_n (rst_src_n),
    .data_b  (rate_src),
    .upd_b   (rate_upd_src)
  );

  pcc_pulse_gen #(.RATE_W(RATE_W)) u_gen (
    .clk   (clk_src),
    .rst_n (rst_src_n),
    .en    (en_src),
    .rate  (rate_src),
    .pulse (pulse_src)
  );

  pcc_pulse_sync u_pulse_sync (
    .clk_a   (clk_src),
    .rst_a_n (rst_src_n),
    .pulse_a (pulse_src),
    .clk_b   (clk_dst),
    .rst_b_n (rst_dst_n),
    .pulse_b (strobe_dst)
  );

  // Three counting paths: reference, raw crossing, synchronized crossing.
  localparam int unsigned NPATH = 3;
  logic               path_clk [NPATH];
  logic               path_rst [NPATH];
  logic               path_inc [NPATH];
  logic [COUNT_W-1:0] path_cnt [NPATH];

  always_comb begin
    path_clk[0] = clk_src; path_rst[0] = rst_src_n; path_inc[0] = pulse_src;
    path_clk[1] = clk_dst; path_rst[1] = rst_dst_n; path_inc[1] = pulse_src;
    path_clk[2] = clk_dst; path_rst[2] = rst_dst_n; path_inc[2] = strobe_dst;
  end

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    pcc_counter #(.WIDTH(COUNT_W)) u_cnt (
      .clk   (path_clk[g]),
      .rst_n (path_rst[g]),
      .inc   (path_inc[g]),
      .count (path_cnt[g])
    );
  end

  assign ref_count_o  = path_cnt[0];
  assign raw_count_o  = path_cnt[1];
  assign sync_count_o = path_cnt[2];
endmodule

// File: rtl/xdom_pulse_counter_chk.sv
module xdom_pulse_counter_chk #(
  parameter int unsigned COUNT_W = 24,
  parameter int unsigned RATE_W  = 24
) (
  input logic               clk_src,
  input logic               rst_src_n,
  input logic               clk_dst,
  input logic               rst_dst_n,
  input logic               en_src,
  input logic [RATE_W-1:0]  rate_src,
  input logic               rate_upd_src,
  input logic               pulse_src,
  input logic               strobe_dst,
  input logic [COUNT_W-1:0] ref_count,
  input logic [COUNT_W-1:0] raw_count,
  input logic [COUNT_W-1:0] sync_count
);
  // R1
  pulse_width_chk: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    (pulse_src && rate_src != '0) |=> !pulse_src);

  // R2
  ref_step_chk: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    pulse_src |=> (ref_count - $past(ref_count)) == COUNT_W'(1));

  // R2
  ref_hold_chk: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    !pulse_src |=> $stable(ref_count));

  // R3
  raw_idle_chk: assert property (@(posedge clk_dst) disable iff (!rst_dst_n)
    !pulse_src |=> $stable(raw_count));

  // R4
  strobe_width_chk: assert property (@(posedge clk_dst) disable iff (!rst_dst_n)
    strobe_dst |=> !strobe_dst);

  // R4
  sync_step_chk: assert property (@(posedge clk_dst) disable iff (!rst_dst_n)
    strobe_dst |=> (sync_count - $past(sync_count)) == COUNT_W'(1));

  // R5
  idle_gen_chk: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    !en_src |=> !pulse_src);

  // R6
  rate_hold_chk: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    !rate_upd_src |=> $stable(rate_src));
endmodule

bind xdom_pulse_counter xdom_pulse_counter_chk #(
  .COUNT_W (COUNT_W),
  .RATE_W  (RATE_W)
) u_chk (
  .clk_src      (clk_src),
  .rst_src_n    (rst_src_n),
  .clk_dst      (clk_dst),
  .rst_dst_n    (rst_dst_n),
  .en_src       (en_src),
  .rate_src     (rate_src),
  .rate_upd_src (rate_upd_src),
  .pulse_src    (pulse_src),
  .strobe_dst   (strobe_dst),
  .ref_count    (ref_count_o),
  .raw_count    (raw_count_o),
  .sync_count   (sync_count_o)
);

// File: tb/sim_xdom_pulse_counter.sv
`timescale 1ns/1ps
module sim_xdom_pulse_counter;
  localparam int unsigned CW = 8;
  localparam int unsigned RW = 24;
  localparam int unsigned DEF_RATE = 15;

  // {direction (0: src 50 MHz / dst 141.4 MHz, 1: reversed), rate, pulses in window}
  localparam int unsigned NVEC = 6;
  localparam int unsigned VEC [NVEC][3] = '{
    '{0, 1, 30}, '{0, 4, 40}, '{0, 9, 25},
    '{1, 7, 20}, '{1, 13, 30}, '{1, 19, 40}
  };

  logic clk_src, clk_dst, rst_src_n, rst_dst_n;
  logic gen_en, rate_load;
  logic [RW-1:0] rate_in;
  logic [CW-1:0] ref_c, raw_c, sync_c;
  real hs, hd;
  int checks, errors;
  bit done;

  xdom_pulse_counter #(.COUNT_W(CW), .RATE_W(RW), .RATE_RST(DEF_RATE)) u0 (
    .clk_src(clk_src), .rst_src_n(rst_src_n), .clk_dst(clk_dst), .rst_dst_n(rst_dst_n),
    .gen_en_i(gen_en), .rate_i(rate_in), .rate_load_i(rate_load),
    .ref_count_o(ref_c), .raw_count_o(raw_c), .sync_count_o(sync_c)
  );

  initial begin hs = 10.0; hd = 3.535; end
  initial begin clk_src = 0; #1; forever #(hs) clk_src = ~clk_src; end
  initial begin clk_dst = 0; #1; forever #(hd) clk_dst = ~clk_dst; end

  // Wrap / single-step monitor on the reference count (R8)
  logic [CW-1:0] mon_prev;
  int step_viol;
  bit wrapped;
  initial begin step_viol = 0; wrapped = 0; mon_prev = '0; end
  always @(negedge clk_src) begin
    if (!rst_src_n) mon_prev = '0;
    else begin
      if (ref_c != mon_prev) begin
        if (ref_c != CW'(mon_prev + 1'b1)) step_viol++;
        if (mon_prev == '1 && ref_c == '0) wrapped = 1;
      end
      mon_prev = ref_c;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk_dst);
    repeat (12) @(negedge clk_src);
  endtask

  task automatic load_rate(input int unsigned v, input bit drop);
    @(negedge clk_dst);
    rate_in = RW'(v);
    rate_load = 1'b1;
    repeat (3) @(negedge clk_dst);
    if (drop) rate_load = 1'b0;
    settle();
  endtask

  task automatic set_en(input bit v);
    @(negedge clk_dst);
    gen_en = v;
    settle();
    if (!v) repeat (20) @(negedge clk_dst);
  endtask

  task automatic set_dir(input int unsigned d);
    if (d == 0) begin hs = 10.0; hd = 3.535; end
    else        begin hs = 3.535; hd = 10.0; end
    settle();
  endtask

  task automatic window(input int unsigned r, input int unsigned k,
                        output int dref, output int draw);
    logic [CW-1:0] r0, w0, r1, w1;
    repeat (2 * (r + 1)) @(negedge clk_src);
    r0 = ref_c; w0 = raw_c;
    repeat (k * (r + 1)) @(negedge clk_src);
    r1 = ref_c; w1 = raw_c;
    dref = int'(CW'(r1 - r0));
    draw = int'(CW'(w1 - w0));
  endtask

  task automatic hold_check(input string tag);
    logic [CW-1:0] a, b, c;
    a = ref_c; b = raw_c; c = sync_c;
    repeat (100) @(negedge clk_dst);
    check(a == ref_c && b == raw_c && c == sync_c, tag,
          int'(ref_c) + int'(raw_c) + int'(sync_c), int'(a) + int'(b) + int'(c));
  endtask

  initial begin
    int dref, draw;
    checks = 0; errors = 0; done = 0;
    rst_src_n = 0; rst_dst_n = 0;
    gen_en = 0; rate_load = 0; rate_in = '0;
    #100;
    @(negedge clk_src) rst_src_n = 1;
    @(negedge clk_dst) rst_dst_n = 1;

    // R7: reset state
    @(negedge clk_src);
    check(ref_c == 0 && raw_c == 0 && sync_c == 0, "R7 counts zero after reset",
          int'(ref_c) + int'(raw_c) + int'(sync_c), 0);
    // R5 / R7: idle until enabled
    repeat (60) @(negedge clk_src);
    check(ref_c == 0 && raw_c == 0 && sync_c == 0, "R5 idle before enable",
          int'(ref_c) + int'(raw_c) + int'(sync_c), 0);

    // R7: default rate spacing with no load
    set_en(1);
    window(DEF_RATE, 10, dref, draw);
    check(dref == 10, "R7 default rate spacing", dref, 10);

    // R1: shrink rate below the running phase
    load_rate(200, 1);
    repeat (120) @(negedge clk_src);
    load_rate(3, 1);
    window(3, 12, dref, draw);
    check(dref == 12, "R1 rate lowered under phase", dref, 12);

    // R6: flag kept high, later rate input change ignored
    load_rate(9, 0);
    @(negedge clk_dst) rate_in = RW'(2);
    settle();
    window(9, 10, dref, draw);
    check(dref == 10, "R6 held flag ignores new rate", dref, 10);
    @(negedge clk_dst) rate_load = 1'b0;
    set_en(0);
    check(sync_c == ref_c, "R4 sync equals ref (directed)", int'(sync_c), int'(ref_c));

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      set_dir(VEC[i][0]);
      load_rate(VEC[i][1], 1);
      set_en(1);
      window(VEC[i][1], VEC[i][2], dref, draw);
      check(dref == int'(VEC[i][2]), "R1 R2 pulse spacing", dref, int'(VEC[i][2]));
      if (VEC[i][0] == 0)
        check(draw >= 2 * dref, "R3 raw overcount fast dst", draw, 2 * dref);
      else
        check(draw < dref, "R3 raw undercount slow dst", draw, dref);
      set_en(0);
      check(sync_c == ref_c, "R4 sync equals ref", int'(sync_c), int'(ref_c));
      hold_check("R5 counts hold while disabled");
    end

    // R8: long run to force wrap
    set_dir(0);
    load_rate(1, 1);
    set_en(1);
    repeat (600) @(negedge clk_src);
    set_en(0);
    check(wrapped && step_viol == 0, "R8 wrap with unit steps", step_viol, 0);
    check(sync_c == ref_c, "R4 sync equals ref after wrap", int'(sync_c), int'(ref_c));

    // R7: asynchronous reset while running
    set_en(1);
    repeat (37) @(negedge clk_src);
    #3.3;
    rst_src_n = 0; rst_dst_n = 0;
    #1;
    check(ref_c == 0 && raw_c == 0 && sync_c == 0, "R7 async clear mid-run",
          int'(ref_c) + int'(raw_c) + int'(sync_c), 0);
    repeat (3) @(negedge clk_src);
    @(negedge clk_src) rst_src_n = 1;
    @(negedge clk_dst) rst_dst_n = 1;
    settle();
    window(DEF_RATE, 8, dref, draw);
    check(dref == 8, "R7 rate back to default", dref, 8);
    set_en(0);
    check(sync_c == ref_c, "R4 sync equals ref after reset", int'(sync_c), int'(ref_c));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule